// File: doc/BRIEF.md
# Write-Triggered FIFO Status Timer

This block produces the three timed flags of a status word that tracks a bus write FIFO. Each write strobe launches a staggered sequence: a "hot" flag (bit 5) rises at once, a "middle" flag (bit 4) follows after a delay, and a "low" flag (bit 0) follows after a longer delay. Each flag then stays high for a fixed number of clock ticks. The FIFO data path itself is not part of this block.

Writes that arrive close together keep the flags high for longer. If a write lands while a flag's off-timer is running, that flag's whole duration is added to the time it has left. A rise that is still pending is never restarted or moved. All tick counts are parameters. The counters saturate at their maximum value and never wrap.

Each flag is handled by its own lane. A lane holds an optional rise (on) timer and a fall (off) timer, plus a four-state machine:

- `LN_IDLE`: flag low, no rise pending.
- `LN_ARMED`: flag low, rise pending.
- `LN_HIGH`: flag high.
- `LN_HIGH_ARMED`: flag high and the rise timer running again.

The transitions are:

- `write` starts a rise in `LN_IDLE`, or raises the hot flag at once.
- `rise expiry` moves `LN_ARMED` to `LN_HIGH`.
- `fall expiry` returns a lane to `LN_IDLE`.
- A `write` while high can move a lane to `LN_HIGH_ARMED`.

A one-cycle read port captures the status word.

Top module: `wfifo_status_timer`

## Requirements
- R1: With default parameters, when a single write is sampled at edge k, status bit 5 reads 1 after edges k through k+59 and reads 0 after edge k+60.
- R2: After a single write at edge k, status bit 4 reads 0 up to edge k+59, reads 1 after edges k+60 through k+219, and reads 0 after edge k+220.
- R3: After a single write at edge k, status bit 0 reads 0 up to edge k+119, reads 1 after edges k+120 through k+539, and reads 0 after edge k+540.
- R4: A write sampled while a flag's off-timer runs adds 60 (bit 5), 160 (bit 4) or 420 (bit 0) ticks to the fall deadline. For writes at k and k+20, bit 5 falls at k+120, bit 4 at k+380 and bit 0 at k+960.
- R5: A write sampled while a flag's rise is still pending leaves the rise edge unchanged. For writes at k and k+20, bit 4 still rises at k+60 and bit 0 at k+120.
- R6: Once a flag's timers have expired they are idle, and a later write starts a fresh sequence. For writes at k and k+100, bit 5 rises again at k+100 and falls at k+160.
- R7: Reset clears all flags, all timers and the read data. No flag rises after a reset that interrupts a running sequence.
- R8: Extension saturates at 2^CNT_W-1 (65535 by default). With writes on 500 consecutive edges, the last at edge L, bits 4 and 0 fall at edge L+65535 and bit 5 falls at L+29501.
- R9: Status bits other than 5, 4 and 0 always read 0.
- R10: When rd_en is sampled high at an edge, rd_data takes the status value held just before that edge. Otherwise rd_data holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One write into the FIFO per sampled high cycle |
| rd_en | input | 1 | Capture the status word into rd_data |
| status | output | 32 | Live status word (bits 5, 4, 0 used) |
| rd_data | output | 32 | Captured status word |

## Verification
Each flag changes right after the clock edge named in its requirement: the hot flag changes at the sampling edge, and the other two change a fixed number of edges later. rd_data follows one edge after rd_en. The bench drives inputs and samples outputs on falling edges. It keeps a relative edge count from the write under test, and it checks each deadline both one edge before it is due and at the edge where it is due. The saturation case checks the fall one edge early and exactly at the 65535-edge limit.

// File: rtl/wfst_pkg.sv
package wfst_pkg;
    typedef enum logic [1:0] {
        LN_IDLE       = 2'd0,
        LN_ARMED      = 2'd1,
        LN_HIGH       = 2'd2,
        LN_HIGH_ARMED = 2'd3
    } lane_state_t;

    localparam int LANES  = 3;
    localparam int STAT_W = 32;
endpackage

// File: rtl/wfst_down_timer.sv
module wfst_down_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] start_val,
    input  logic          extend,
    input  logic [CW-1:0] ext_val,
    output logic          busy,
    output logic          expire,
    output logic [CW-1:0] count
);
    logic [CW:0]   sum;
    logic [CW-1:0] ext_next;

    always_comb begin
        sum      = {1'b0, count} - {{CW{1'b0}}, 1'b1} + {1'b0, ext_val};
        ext_next = sum[CW] ? {CW{1'b1}} : sum[CW-1:0];
        expire   = busy && (count == CW'(1)) && !extend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            count <= '0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                count <= start_val;
            end
        end else if (extend) begin
            count <= ext_next;
        end else if (count == CW'(1)) begin
            busy  <= 1'b0;
            count <= '0;
        end else begin
            count <= count - CW'(1);
        end
    end

    // R8: an extension never makes the remaining time shorter
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && extend |=> count >= $past(count));
    // R6: an expired timer is idle
    p_expire_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !busy);
endmodule

// File: rtl/wfst_flag_lane.sv
module wfst_flag_lane
    import wfst_pkg::*;
#(
    parameter int CW       = 16,
    parameter int RISE_DLY = 0,
    parameter int HOLD     = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    output logic flag
);
    localparam bit        HAS_RISE = (RISE_DLY > 0);
    localparam int        MAXV     = (1 << CW) - 1;
    localparam int        FRESH_I  = RISE_DLY + HOLD;
    localparam logic [CW-1:0] FRESH = (FRESH_I > MAXV) ? CW'(MAXV) : CW'(FRESH_I);

    lane_state_t   st, st_n;
    logic          on_busy, on_exp, on_start;
    logic [CW-1:0] on_cnt;
    logic          off_busy, off_exp, off_start, off_ext;
    logic [CW-1:0] off_cnt;
    logic          set_ev, flag_n, pend_n;

    generate
        if (HAS_RISE) begin : g_rise
            assign on_start = wr && !on_busy;
            wfst_down_timer #(.CW(CW)) u_on (
                .clk(clk), .rst_n(rst_n),
                .start(on_start), .start_val(CW'(RISE_DLY)),
                .extend(1'b0), .ext_val('0),
                .busy(on_busy), .expire(on_exp), .count(on_cnt)
            );
            assign set_ev = on_exp;

            // R5: a pending rise is neither restarted nor moved by a write
            p_on_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
                on_busy && wr && !on_exp |=> on_cnt == $past(on_cnt) - CW'(1));
            // R4: a running rise always has a running fall behind it
            p_on_needs_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
                on_busy |-> off_busy);
        end else begin : g_norise
            assign on_start = 1'b0;
            assign on_busy  = 1'b0;
            assign on_exp   = 1'b0;
            assign on_cnt   = '0;
            assign set_ev   = wr;

            // R1: the immediate flag is high right after a write
            p_flag_on_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
                wr |=> flag);
        end
    endgenerate

    assign off_start = wr && !off_busy;
    assign off_ext   = wr && off_busy;

    wfst_down_timer #(.CW(CW)) u_off (
        .clk(clk), .rst_n(rst_n),
        .start(off_start), .start_val(FRESH),
        .extend(off_ext), .ext_val(CW'(HOLD)),
        .busy(off_busy), .expire(off_exp), .count(off_cnt)
    );

    always_comb begin
        flag_n = set_ev ? 1'b1 : (off_exp ? 1'b0 : flag);
        pend_n = (on_busy && !on_exp) || on_start;
        unique case ({flag_n, pend_n})
            2'b00:   st_n = LN_IDLE;
            2'b01:   st_n = LN_ARMED;
            2'b10:   st_n = LN_HIGH;
            default: st_n = LN_HIGH_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= LN_IDLE;
        else        st <= st_n;
    end

    always_comb begin
        unique case (st)
            LN_IDLE, LN_ARMED:      flag = 1'b0;
            LN_HIGH, LN_HIGH_ARMED: flag = 1'b1;
            default:                flag = 1'b0;
        endcase
    end

    // R2: a fall expiry with no rise in the same cycle leaves the flag low
    p_off_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        off_exp && !set_ev |=> !flag);
endmodule

// File: rtl/wfifo_status_timer.sv
module wfifo_status_timer
    import wfst_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int HOT_TICKS = 60,
    parameter int MID_DELAY = 60,
    parameter int MID_TICKS = 160,
    parameter int LOW_DELAY = 120,
    parameter int LOW_TICKS = 420
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_en,
    output logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] rd_data
);
    localparam int LANE_BIT  [LANES] = '{5, 4, 0};
    localparam int LANE_DLY  [LANES] = '{0, MID_DELAY, LOW_DELAY};
    localparam int LANE_HOLD [LANES] = '{HOT_TICKS, MID_TICKS, LOW_TICKS};

    logic [LANES-1:0] flags;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            wfst_flag_lane #(
                .CW(CNT_W), .RISE_DLY(LANE_DLY[g]), .HOLD(LANE_HOLD[g])
            ) u_lane (
                .clk(clk), .rst_n(rst_n), .wr(wr_stb), .flag(flags[g])
            );
        end
    endgenerate

    always_comb begin
        status = '0;
        for (int i = 0; i < LANES; i++) status[LANE_BIT[i]] = flags[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= status;
    end

    // R10: without a read request the captured word does not change
    p_read_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: tb/sim_wfifo_status_timer.sv
`timescale 1ns/1ps
module sim_wfifo_status_timer;
    localparam int CW   = 16;
    localparam int MAXV = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] status, rd_data;

    int n_run = 0;
    int n_fail = 0;
    int rel = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wfifo_status_timer #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_en(rd_en),
        .status(status), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s at rel %0d: got %h expected %h", tag, rel, got, exp);
        end
    endtask

    task automatic goto(input int j);
        while (rel < j) begin
            @(negedge clk);
            rel++;
        end
    endtask

    task automatic first_write();
        @(negedge clk); wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0;
        rel = 0;
    endtask

    task automatic pulse_at(input int j);
        goto(j - 1); wr_stb = 1'b1;
        goto(j);     wr_stb = 1'b0;
    endtask

    task automatic t_reset();
        chk("R7 reset status", status, 32'h0);
        chk("R7 reset rd_data", rd_data, 32'h0);
    endtask

    task automatic t_single();
        first_write();
        chk("R1 bit5 rises", 32'(status[5]), 1);
        chk("R9 spare bits", status & ~32'h31, 0);
        goto(59);  chk("R1 bit5 still high", 32'(status[5]), 1);
                   chk("R2 bit4 not yet", 32'(status[4]), 0);
        goto(60);  chk("R1 bit5 falls", 32'(status[5]), 0);
                   chk("R2 bit4 rises", 32'(status[4]), 1);
        goto(119); chk("R3 bit0 not yet", 32'(status[0]), 0);
        goto(120); chk("R3 bit0 rises", 32'(status[0]), 1);
                   chk("R9 word", status, 32'h11);
        goto(219); chk("R2 bit4 still high", 32'(status[4]), 1);
        goto(220); chk("R2 bit4 falls", 32'(status[4]), 0);
        goto(539); chk("R3 bit0 still high", 32'(status[0]), 1);
        goto(540); chk("R3 bit0 falls", 32'(status[0]), 0);
        goto(600);
    endtask

    task automatic t_extend();
        first_write();
        pulse_at(20);
        goto(59);  chk("R5 bit4 rise not moved early", 32'(status[4]), 0);
        goto(60);  chk("R5 bit4 rise at 60", 32'(status[4]), 1);
        goto(119); chk("R4 bit5 extended", 32'(status[5]), 1);
                   chk("R5 bit0 not yet", 32'(status[0]), 0);
        goto(120); chk("R4 bit5 falls at 120", 32'(status[5]), 0);
                   chk("R5 bit0 rise at 120", 32'(status[0]), 1);
        goto(379); chk("R4 bit4 extended", 32'(status[4]), 1);
        goto(380); chk("R4 bit4 falls at 380", 32'(status[4]), 0);
        goto(959); chk("R4 bit0 extended", 32'(status[0]), 1);
        goto(960); chk("R4 bit0 falls at 960", 32'(status[0]), 0);
                   chk("R9 idle word", status, 0);
        goto(1000);
    endtask

    task automatic t_late();
        first_write();
        goto(99);  chk("R6 bit5 idle before rewrite", 32'(status[5]), 0);
        pulse_at(100);
        chk("R6 bit5 fresh rise", 32'(status[5]), 1);
        goto(119); chk("R5 bit0 pending kept", 32'(status[0]), 0);
        goto(120); chk("R5 bit0 rises at 120", 32'(status[0]), 1);
        goto(159); chk("R6 bit5 high", 32'(status[5]), 1);
        goto(160); chk("R6 bit5 falls at 160", 32'(status[5]), 0);
                   chk("R4 bit4 stays high", 32'(status[4]), 1);
        goto(379); chk("R4 bit4 late extend", 32'(status[4]), 1);
        goto(380); chk("R4 bit4 falls at 380", 32'(status[4]), 0);
        goto(959); chk("R4 bit0 late extend", 32'(status[0]), 1);
        goto(960); chk("R4 bit0 falls at 960", 32'(status[0]), 0);
        goto(1000);
    endtask

    task automatic t_read();
        first_write();
        goto(10); rd_en = 1'b1;
        goto(11); rd_en = 1'b0;
        chk("R10 capture", rd_data, 32'h20);
        goto(70);
        chk("R10 hold while status changes", rd_data, 32'h20);
        chk("R9 status at 70", status, 32'h10);
        goto(600);
    endtask

    task automatic t_midreset();
        first_write();
        goto(30);
        rst_n = 1'b0;
        goto(32);
        rst_n = 1'b1;
        chk("R7 cleared by reset", status, 0);
        chk("R7 rd_data cleared", rd_data, 0);
        goto(300);
        chk("R7 no late rise after reset", status, 0);
    endtask

    task automatic t_saturate();
        @(negedge clk); wr_stb = 1'b1;
        rel = -1;
        goto(499); wr_stb = 1'b0;
        goto(29999); chk("R8 bit5 high", 32'(status[5]), 1);
        goto(30000); chk("R8 bit5 falls at L+29501", 32'(status[5]), 0);
        goto(499 + MAXV - 1);
        chk("R8 bit4 saturated high", 32'(status[4]), 1);
        chk("R8 bit0 saturated high", 32'(status[0]), 1);
        goto(499 + MAXV);
        chk("R8 bit4 falls at limit", 32'(status[4]), 0);
        chk("R8 bit0 falls at limit", 32'(status[0]), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_extend();
        t_late();
        t_read();
        t_midreset();
        t_saturate();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule